// File: doc/BRIEF.md
# Bit Field Extract/Insert Unit

This unit reads one 16-bit word from a synchronous memory and either returns a bit field taken from it or replaces that field and stores the word back. The field is given by an 8-bit descriptor. Its upper nibble is the index of the field's first bit, counted from the most significant bit (index 0 is bit 15). Its lower nibble is the field width minus one. A field whose end runs past bit 0 wraps around to bit 15. The word address is a base address plus an 8-bit offset.

The unit works in rotated space. It looks up a right-justified mask from the width nibble. A single-cycle barrel rotator turns the word left by (first + width-minus-one + 1) mod 16, which brings the field down to bit 0. An extract returns the rotated word ANDed with the mask. An insert clears the masked bits, ORs in the masked new data, rotates the word back by (16 - count) mod 16 and writes it to the same address.

Commands enter on a valid/ready channel and results leave on a valid/ready channel. A command is taken when `cmd_valid` and `cmd_ready` are both high at a clock edge. The unit then accepts nothing until its result has been taken. A result is held, unchanged, for as long as `res_ready` stays low. Back-pressure on the result therefore stalls the command input.

Top module: `bfx_unit`

## Requirements
- R1: After reset, `cmd_ready` is 1, and `res_valid` and `mem_req` are 0.
- R2: A width nibble n selects a mask with exactly bits n..0 set. The result of an extract has every bit above n at zero.
- R3: For an extract with first index p and width w = n+1, result bit i (for i < w) equals word bit (16 - p - w + i) mod 16, with bits numbered from the LSB. Fields that wrap past bit 0 follow the same rule.
- R4: The memory address used for both the read and the write is (base + zero-extended offset) mod 2^ADDR_W.
- R5: An insert replaces exactly the field bits with the low w bits of `cmd_data`. Data bits above the field width are ignored, and every other bit of the word is unchanged in memory.
- R6: When p + w = 16, the rotate count is zero and the field sits at the low end of the word. Both extract and insert must produce correct results in this case, and no rotation is applied.
- R7: The read request is issued in the cycle after acceptance, with `mem_rdata` used one cycle later. An extract makes exactly one read. An insert makes one read and then one write (`mem_we`=1) two cycles after that read. No other memory requests occur.
- R8: `res_valid` rises 3 cycles after acceptance for an extract and 4 cycles after acceptance for an insert. While `res_valid` is high and `res_ready` is low, `res_valid` and `res_data` hold steady. `cmd_ready` is low from acceptance until the result is taken.
- R9: For an insert, `res_data` equals the word that was written to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command can be taken |
| cmd_insert | input | 1 | 1 = insert, 0 = extract |
| cmd_base | input | ADDR_W | Base word address |
| cmd_offset | input | OFF_W | Offset added to base |
| cmd_desc | input | 2*log2(DATA_W) | Field descriptor: upper nibble first index, lower nibble width-1 |
| cmd_data | input | DATA_W | New field data for insert |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result taken by consumer |
| res_data | output | DATA_W | Extracted field, or written word for insert |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, one cycle after a read request |

## Verification
Two events can fall in the same cycle: the result is stalled by a low `res_ready`, and a fresh command is presented on `cmd_valid`. The bench provokes this by holding `res_ready` low for several cycles while it drives a second command. It then checks that the command is refused, that no memory request appears and that the held result does not change. The bench also sweeps every first-index and width pair in both directions. Each outcome is judged against a shift-and-mask model kept in the bench, and the memory pins are compared against the expected access schedule on every clock.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CAPT,
    ST_WRITE,
    ST_RESP
  } bfx_state_e;
endpackage

// File: rtl/bfx_mask_gen.sv
module bfx_mask_gen #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [IDX_W-1:0]  wid_m1,
  output logic [DATA_W-1:0] mask
);
  // Right-justified mask: entry n has bits n..0 set
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign mask[i] = ({1'b0, wid_m1} >= (IDX_W+1)'(i));
  end

  always_comb begin
    // R2: contiguous from bit 0
    a_r2_mask_shape: assert (mask[0] && ((mask & (mask + DATA_W'(1))) == '0));
  end
endmodule

// File: rtl/bfx_rotl.sv
module bfx_rotl #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stg [0:CNT_W];

  assign stg[0] = din;
  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stg[k+1] = cnt[k] ? {stg[k][DATA_W-1-SH:0], stg[k][DATA_W-1:DATA_W-SH]}
                             : stg[k];
  end
  assign dout = stg[CNT_W];

  always_comb begin
    // R6: a zero count passes the word through untouched
    a_r6_zero_count: assert (cnt != '0 || dout == din);
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int OFF_W  = 8,
  localparam int IDX_W  = $clog2(DATA_W),
  localparam int DESC_W = 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_insert,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [OFF_W-1:0]  cmd_offset,
  input  logic [DESC_W-1:0] cmd_desc,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  import bfx_pkg::*;

  bfx_state_e        state_q, state_d;
  logic              ins_q;
  logic [IDX_W-1:0]  pos_q, wm1_q;
  logic [DATA_W-1:0] data_q, out_q;
  logic [ADDR_W-1:0] addr_q;

  logic [IDX_W-1:0]  rot_cnt, back_cnt;
  logic [DATA_W-1:0] mask, rot_w, merged, ins_w, ext_w;

  assign rot_cnt  = pos_q + wm1_q + IDX_W'(1);
  assign back_cnt = IDX_W'(0) - rot_cnt;

  bfx_mask_gen #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mask (
    .wid_m1 (wm1_q),
    .mask   (mask)
  );

  bfx_rotl #(.DATA_W(DATA_W), .CNT_W(IDX_W)) u_rot_fwd (
    .din  (mem_rdata),
    .cnt  (rot_cnt),
    .dout (rot_w)
  );

  assign ext_w  = rot_w & mask;
  assign merged = (rot_w & ~mask) | (data_q & mask);

  bfx_rotl #(.DATA_W(DATA_W), .CNT_W(IDX_W)) u_rot_back (
    .din  (merged),
    .cnt  (back_cnt),
    .dout (ins_w)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cmd_valid) state_d = ST_READ;
      ST_READ:  state_d = ST_CAPT;
      ST_CAPT:  state_d = ins_q ? ST_WRITE : ST_RESP;
      ST_WRITE: state_d = ST_RESP;
      ST_RESP:  if (res_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ins_q   <= 1'b0;
      pos_q   <= '0;
      wm1_q   <= '0;
      data_q  <= '0;
      addr_q  <= '0;
      out_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && cmd_valid) begin
        ins_q  <= cmd_insert;
        pos_q  <= cmd_desc[DESC_W-1:IDX_W];
        wm1_q  <= cmd_desc[IDX_W-1:0];
        data_q <= cmd_data;
        addr_q <= cmd_base + ADDR_W'(cmd_offset);
      end
      if (state_q == ST_CAPT) out_q <= ins_q ? ins_w : ext_w;
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign res_valid = (state_q == ST_RESP);
  assign res_data  = out_q;
  assign mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = out_q;

  // R8: held result stays put under back-pressure
  a_r8_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));

  // R8: no second command while one is in flight
  a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  // R4/R7: write lands on the read address, two cycles after the read
  a_r4_write_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> $past(mem_req, 2) && !$past(mem_we, 2)
                          && mem_addr == $past(mem_addr, 2));

  // R7: accesses never come back to back
  a_r7_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
endmodule

// File: tb/bfx_unit_tb.sv
module bfx_unit_tb;
  localparam int DW = 16;
  localparam int AW = 10;
  localparam int OW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0, cmd_insert = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_base = '0;
  logic [OW-1:0] cmd_offset = '0;
  logic [7:0]    cmd_desc = '0;
  logic [DW-1:0] cmd_data = '0;
  logic          res_valid, res_ready = 1'b0;
  logic [DW-1:0] res_data;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bfx_unit #(.DATA_W(DW), .ADDR_W(AW), .OFF_W(OW)) u_dut (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_insert, .cmd_base, .cmd_offset,
    .cmd_desc, .cmd_data, .res_valid, .res_ready, .res_data,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  function automatic logic [DW-1:0] ref_ext(logic [DW-1:0] w, int p, int n);
    logic [DW-1:0] r = '0;
    for (int i = 0; i <= n; i++) r[i] = w[(DW - p - (n+1) + i + DW) % DW];
    return r;
  endfunction

  function automatic logic [DW-1:0] ref_ins(logic [DW-1:0] w, int p, int n, logic [DW-1:0] d);
    logic [DW-1:0] r = w;
    for (int i = 0; i <= n; i++) r[(DW - p - (n+1) + i + DW) % DW] = d[i];
    return r;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One transaction; per-cycle pin comparison against the expected schedule.
  task automatic run(bit ins, logic [AW-1:0] base, logic [OW-1:0] off, int p, int n,
                     logic [DW-1:0] d, int stall);
    logic [AW-1:0] a = base + AW'(off);
    logic [DW-1:0] orig = mem[a];
    logic [DW-1:0] exp = ins ? ref_ins(orig, p, n, d) : ref_ext(orig, p, n);
    int bad = 0;
    int last = ins ? 4 : 3;
    @(negedge clk);
    cmd_valid = 1; cmd_insert = ins; cmd_base = base; cmd_offset = off;
    cmd_desc = {4'(p), 4'(n)}; cmd_data = d;
    if (!cmd_ready) bad++;
    @(negedge clk);
    cmd_valid = 0;
    for (int c = 1; c <= last; c++) begin
      // R7: read at c=1, write at c=3 for insert, nothing else
      if (mem_req !== (c == 1 || (ins && c == 3))) bad++;
      if (mem_req && mem_addr !== a) bad++;                 // R4
      if (mem_req && mem_we !== (c == 3)) bad++;
      if (res_valid !== (c == last)) bad++;                 // R8
      if (cmd_ready !== 1'b0) bad++;
      if (c < last) @(negedge clk);
    end
    check("R7 access schedule", DW'(bad), '0);
    check(ins ? "R5 insert result" : "R3 extract result", res_data, exp);
    if (ins) check("R5 memory word", mem[a], exp);
    if (stall > 0) begin
      cmd_valid = 1; cmd_insert = 0;
      bad = 0;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        if (!res_valid || res_data !== exp || cmd_ready || mem_req) bad++;
      end
      cmd_valid = 0;
      check("R8 stall with pending command", DW'(bad), '0);
    end
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
    check("R8 release", {14'd0, res_valid, cmd_ready}, 16'b01);
  endtask

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = DW'(i * 40503) ^ 16'h5A5A;
    repeat (3) @(negedge clk);
    check("R1 reset state", {13'd0, cmd_ready, res_valid, mem_req}, 16'b100);
    rst_n = 1;

    for (int p = 0; p < 16; p++)
      for (int n = 0; n < 16; n++)
        run(0, AW'(p * 37), OW'(n * 11), p, n, '0, 0);
    for (int p = 0; p < 16; p++)
      for (int n = 0; n < 16; n++)
        run(1, AW'(p * 53 + 7), OW'(n * 5), p, n, DW'((p * 16 + n) * 2654) ^ 16'hC3A5, 0);

    // R6: zero rotate count (p + w = 16)
    mem[AW'(100)] = 16'hBEEF;
    run(0, AW'(100), '0, 12, 3, '0, 0);
    check("R6 low-end extract", res_data, 16'h000F);
    run(1, AW'(100), '0, 12, 3, 16'hFFF5, 0);
    check("R6 low-end insert", mem[AW'(100)], 16'hBEE5);

    // R2: bits above width are zero; R5: data above width ignored
    mem[AW'(200)] = 16'hFFFF;
    run(0, AW'(200), '0, 4, 2, '0, 0);
    check("R2 mask width", res_data, 16'h0007);
    mem[AW'(201)] = 16'h0000;
    run(1, AW'(201), '0, 0, 0, 16'hFFFE, 0);
    check("R5 high data ignored", mem[AW'(201)], 16'h0000);

    // R4: address wraps at 2^ADDR_W
    mem[AW'(5)] = 16'h1234;
    run(0, AW'(1020), OW'(9), 0, 15, '0, 0);
    check("R4 address wrap", res_data, 16'h1234);

    // R8/R9: result stall while a new command waits
    mem[AW'(300)] = 16'h0F0F;
    run(1, AW'(300), '0, 2, 7, 16'h00AA, 5);
    check("R9 insert returns written word", mem[AW'(300)], 16'h2A8F);
    run(0, AW'(300), '0, 2, 7, '0, 4);
    check("R8 extract after stall", res_data, 16'h00AA);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule